// File: doc/BRIEF.md
# Infrared Carrier Transmit Engine

This block drives an infrared emitter. It divides the system clock by a selectable power of two to make an IR tick. From that tick it builds a rectangular carrier whose high and low phases are each programmed in ticks. A 16-bit down-counter cuts the output into modulation intervals. During each interval a data bit decides whether the pin shows the carrier or holds its idle level. The down-counter steps once per carrier period or once per IR tick, depending on a step-source select.

The carrier timing, data bit, polarity, divider, interval length and step source are all captured together at the start of every interval. Firmware can therefore stage the next symbol while the current one plays out, and frequency or duty cycle can change from one interval to the next without glitches. When the engine is off, two plain software bits drive the pin and its output enable. A one-cycle pulse marks the end of each interval, and an interrupt output is the gated copy of that pulse.

Top module: `ir_tx_engine`

## Requirements
- R1: The IR tick runs at the system clock divided by 2^div_sel_i. Within an interval the first tick falls on cycle 2^div_sel_i - 1, counting the interval's first cycle as 0.
- R2: Each interval starts with the carrier in its high phase. The carrier is high for (car_hi_i+1) ticks and then low for (car_lo_i+1) ticks, so one period is car_hi_i+car_lo_i+2 ticks.
- R3: With step_ir_i=0 the interval counter steps once per completed carrier period, so an interval lasts (mod_time_i+1) carrier periods.
- R4: With step_ir_i=1 the interval counter steps once per IR tick, so an interval lasts (mod_time_i+1) ticks, even if that ends it partway through a carrier period.
- R5: All interval settings are captured in the first active cycle and again in the last cycle of every interval. These are the carrier bytes, data, polarity, divider, interval length and step source. Changes at other times have no effect until the next interval begins.
- R6: While running, tx_o equals pol ^ (data & carrier_high). With data=0 the pin holds the idle level pol. With pol=0 the carrier high phase drives the pin to 1.
- R7: With en_i=0, tx_o equals sw_level_i and tx_oe_o equals sw_oe_i in the same cycle. With en_i=1, tx_oe_o is 1.
- R8: done_o is high for exactly the last cycle of each interval. irq_o equals done_o when irq_en_i=1 and is 0 otherwise.
- R9: With en_i=1 and tx_mode_i=0, tx_o equals pol_i, tx_oe_o is 1 and done_o stays 0.
- R10: While rst is high and en_i=0, tx_o equals sw_level_i, tx_oe_o equals sw_oe_i and done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Engine enable |
| tx_mode_i | input | 1 | 1 selects transmit operation |
| div_sel_i | input | 2 | IR tick divider exponent |
| car_hi_i | input | 8 | Carrier high phase length minus one, in ticks |
| car_lo_i | input | 8 | Carrier low phase length minus one, in ticks |
| mod_time_i | input | 16 | Interval length minus one, in counter steps |
| data_i | input | 1 | 1 sends carrier, 0 sends idle level |
| pol_i | input | 1 | Idle level and carrier polarity |
| step_ir_i | input | 1 | Counter step source: 0 carrier period, 1 IR tick |
| irq_en_i | input | 1 | Interrupt enable |
| sw_level_i | input | 1 | Pin level when disabled |
| sw_oe_i | input | 1 | Pin output enable when disabled |
| tx_o | output | 1 | IR transmit pin level |
| tx_oe_o | output | 1 | IR transmit pin output enable |
| done_o | output | 1 | Interval end pulse |
| irq_o | output | 1 | Gated interval end interrupt |

## Verification
A wrong tick counter or carrier phase counter shifts a pin edge. That error shows on tx_o within one carrier period of the fault. A wrong interval counter moves done_o and the next capture point, so it appears at the first interval boundary. A capture at the wrong moment leaks a staged setting into the current interval and changes the pin before the boundary. The bench sweeps divider, carrier bytes, interval length and step source, and stages a different configuration halfway through each first interval. It then compares every cycle against an arithmetic model.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

    localparam int CAR_W = 8;
    localparam int MOD_W = 16;
    localparam int DIV_W = 2;
    localparam int PRE_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [CAR_W-1:0] hi;
        logic [CAR_W-1:0] lo;
        logic [MOD_W-1:0] mtime;
        logic [DIV_W-1:0] div;
        logic             step_ir;
        logic             data;
        logic             pol;
    } ir_cfg_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } car_phase_e;

    // Low 'd' bits set: tick fires when all of them are ones.
    function automatic logic [PRE_W-1:0] pre_mask(input logic [DIV_W-1:0] d);
        logic [PRE_W-1:0] m;
        for (int i = 0; i < PRE_W; i++) begin
            m[i] = (i < int'(d));
        end
        return m;
    endfunction

endpackage

// File: rtl/ir_prescaler.sv
module ir_prescaler
    import ir_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] mask;

    assign mask = pre_mask(div);
    assign tick = run && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: with a divider above 1, two ticks never land on neighbouring cycles
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && mask != '0 && !clr) |=> !tick);

endmodule

// File: rtl/ir_carrier.sv
module ir_carrier
    import ir_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CAR_W-1:0] hi,
    input  logic [CAR_W-1:0] lo,
    output logic             car_high,
    output logic             cyc_end
);

    car_phase_e       phase;
    logic [CAR_W-1:0] cnt;
    logic [CAR_W-1:0] limit;
    logic             at_lim;

    assign limit    = (phase == PH_HIGH) ? hi : lo;
    assign at_lim   = (cnt == limit);
    assign car_high = (phase == PH_HIGH);
    assign cyc_end  = tick && (phase == PH_LOW) && at_lim;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= PH_HIGH;
            cnt   <= '0;
        end else if (tick) begin
            if (at_lim) begin
                phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: the phase counter never passes the length of the current phase
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);

    // R2: a tick at the end of a phase swaps the phase
    a_r2_phase_swap: assert property (@(posedge clk) disable iff (rst)
        (tick && at_lim && !clr) |=> (phase != $past(phase)));

endmodule

// File: rtl/ir_modulator.sv
module ir_modulator
    import ir_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  ir_cfg_t          cfg_in,
    input  logic             tick,
    input  logic             cyc_end,
    output ir_cfg_t          cfg_q,
    output logic             running,
    output logic             done,
    output logic             start
);

    logic [MOD_W-1:0] mcnt;
    logic             step;

    assign step  = cfg_q.step_ir ? tick : cyc_end;
    assign done  = active && running && step && (mcnt == '0);
    assign start = active && (!running || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            mcnt    <= '0;
            cfg_q   <= '0;
        end else if (!active) begin
            running <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
            cfg_q   <= cfg_in;
            mcnt    <= cfg_in.mtime;
        end else if (step) begin
            mcnt <= mcnt - 1'b1;
        end
    end

    // R5: captured settings stay put for the whole interval
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (running && !start) |=> $stable(cfg_q));

    // R3: an interval end reloads the counter with the newly captured length
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        done |=> (!running || mcnt == cfg_q.mtime));

    // R4: the counter stays within the captured interval length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        running |-> (mcnt <= cfg_q.mtime));

endmodule

// File: rtl/ir_tx_engine.sv
module ir_tx_engine
    import ir_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tx_mode_i,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic [CAR_W-1:0] car_hi_i,
    input  logic [CAR_W-1:0] car_lo_i,
    input  logic [MOD_W-1:0] mod_time_i,
    input  logic             data_i,
    input  logic             pol_i,
    input  logic             step_ir_i,
    input  logic             irq_en_i,
    input  logic             sw_level_i,
    input  logic             sw_oe_i,
    output logic             tx_o,
    output logic             tx_oe_o,
    output logic             done_o,
    output logic             irq_o
);

    logic    active;
    ir_cfg_t cfg_in;
    ir_cfg_t cfg_q;
    logic    running;
    logic    done;
    logic    start;
    logic    tick;
    logic    car_high;
    logic    cyc_end;
    logic    restart;

    assign active = en_i && tx_mode_i;

    always_comb begin
        cfg_in.hi      = car_hi_i;
        cfg_in.lo      = car_lo_i;
        cfg_in.mtime   = mod_time_i;
        cfg_in.div     = div_sel_i;
        cfg_in.step_ir = step_ir_i;
        cfg_in.data    = data_i;
        cfg_in.pol     = pol_i;
    end

    assign restart = start || !running;

    ir_modulator u_mod (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .cfg_in  (cfg_in),
        .tick    (tick),
        .cyc_end (cyc_end),
        .cfg_q   (cfg_q),
        .running (running),
        .done    (done),
        .start   (start)
    );

    ir_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .clr  (restart),
        .div  (cfg_q.div),
        .tick (tick)
    );

    ir_carrier u_car (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart),
        .tick     (tick),
        .hi       (cfg_q.hi),
        .lo       (cfg_q.lo),
        .car_high (car_high),
        .cyc_end  (cyc_end)
    );

    always_comb begin
        if (!en_i) begin
            tx_o    = sw_level_i;
            tx_oe_o = sw_oe_i;
        end else begin
            tx_oe_o = 1'b1;
            if (running) begin
                tx_o = cfg_q.pol ^ (cfg_q.data & car_high);
            end else begin
                tx_o = pol_i;
            end
        end
    end

    assign done_o = done;
    assign irq_o  = done && irq_en_i;

    // R9: enabled but not transmitting never ends an interval
    a_r9_mode_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (en_i && !tx_mode_i) |-> (!done_o && tx_oe_o));

    // R8: with the interrupt masked no interrupt leaves the block
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |-> !irq_o);

    // R6: data=0 keeps the pin at the captured idle level while running
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (en_i && running && !cfg_q.data) |-> (tx_o == cfg_q.pol));

endmodule

// File: tb/test_ir_tx_engine.sv
module test_ir_tx_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        en_i, tx_mode_i, data_i, pol_i, step_ir_i, irq_en_i;
    logic        sw_level_i, sw_oe_i;
    logic [1:0]  div_sel_i;
    logic [7:0]  car_hi_i, car_lo_i;
    logic [15:0] mod_time_i;
    logic        tx_o, tx_oe_o, done_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // config slots: 0 div, 1 hi, 2 lo, 3 mtime, 4 step_ir, 5 data, 6 pol
    int ca[7];
    int cb[7];

    always #10 clk = ~clk;

    ir_tx_engine i_ir_tx_engine (
        .clk(clk), .rst(rst), .en_i(en_i), .tx_mode_i(tx_mode_i),
        .div_sel_i(div_sel_i), .car_hi_i(car_hi_i), .car_lo_i(car_lo_i),
        .mod_time_i(mod_time_i), .data_i(data_i), .pol_i(pol_i),
        .step_ir_i(step_ir_i), .irq_en_i(irq_en_i), .sw_level_i(sw_level_i),
        .sw_oe_i(sw_oe_i), .tx_o(tx_o), .tx_oe_o(tx_oe_o), .done_o(done_o),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ilen(input int c[7]);
        return (c[3] + 1) * ((c[4] != 0) ? 1 : (c[1] + c[2] + 2)) * (1 << c[0]);
    endfunction

    function automatic logic exp_tx(input int c[7], input int k);
        int ki, per, hw;
        ki  = k % ilen(c);
        per = (c[1] + c[2] + 2) << c[0];
        hw  = (c[1] + 1) << c[0];
        return logic'(c[6] ^ ((c[5] != 0 && (ki % per) < hw) ? 1 : 0));
    endfunction

    function automatic logic exp_done(input int c[7], input int k);
        return logic'((k % ilen(c)) == ilen(c) - 1);
    endfunction

    task automatic apply(input int c[7]);
        div_sel_i  = 2'(c[0]);
        car_hi_i   = 8'(c[1]);
        car_lo_i   = 8'(c[2]);
        mod_time_i = 16'(c[3]);
        step_ir_i  = c[4][0];
        data_i     = c[5][0];
        pol_i      = c[6][0];
    endtask

    // Plays config A for one interval, staging B halfway through it.
    task automatic run_pair(input logic irqen);
        int la, lb, change_at, total;
        logic et, ed;
        string tdone;
        @(negedge clk);
        en_i = 1'b0;
        apply(ca);
        irq_en_i = irqen;
        @(negedge clk);
        en_i = 1'b1;
        tx_mode_i = 1'b1;
        la = ilen(ca);
        lb = ilen(cb);
        change_at = la / 2;
        total = la + 2 * lb;
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            if (k < la) begin
                et = exp_tx(ca, k);
                ed = exp_done(ca, k);
                tdone = (ca[4] != 0) ? "R4 done" : "R3 done";
                chk("R1_R2_R6 tx", tx_o, et);
                chk(tdone, done_o, ed);
            end else begin
                et = exp_tx(cb, k - la);
                ed = exp_done(cb, k - la);
                chk("R5 tx after capture", tx_o, et);
                chk("R5 done after capture", done_o, ed);
            end
            chk("R8 irq", irq_o, ed & irqen);
            chk("R7 oe enabled", tx_oe_o, 1'b1);
            if (k == change_at) apply(cb);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog all requirements: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        en_i = 1'b0; tx_mode_i = 1'b0; data_i = 1'b0; pol_i = 1'b0;
        step_ir_i = 1'b0; irq_en_i = 1'b0; sw_level_i = 1'b1; sw_oe_i = 1'b0;
        div_sel_i = '0; car_hi_i = '0; car_lo_i = '0; mod_time_i = '0;

        // R10: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R10 tx in reset", tx_o, 1'b1);
            chk("R10 oe in reset", tx_oe_o, 1'b0);
            chk("R10 done in reset", done_o, 1'b0);
        end
        @(negedge clk);
        rst = 1'b0;

        // R9: enabled, transmit mode off
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            en_i = 1'b1; tx_mode_i = 1'b0; pol_i = p[0]; data_i = 1'b1;
            mod_time_i = '0; step_ir_i = 1'b1; irq_en_i = 1'b1;
            repeat (12) begin
                @(negedge clk);
                chk("R9 tx idle", tx_o, p[0]);
                chk("R9 oe", tx_oe_o, 1'b1);
                chk("R9 done", done_o, 1'b0);
            end
        end

        // Main sweep across divider, carrier bytes, length and step source
        for (int n = 0; n < 4; n++)
            for (int sel = 0; sel < 2; sel++)
                for (int hi = 0; hi < 3; hi++)
                    for (int lo = 0; lo < 3; lo++)
                        for (int m = 0; m < 3; m++) begin
                            ca[0] = n; ca[1] = hi; ca[2] = lo; ca[3] = m; ca[4] = sel;
                            ca[5] = (((hi + lo + m) % 3) != 0) ? 1 : 0;
                            ca[6] = (lo + n) % 2;
                            cb[0] = (n + hi + 1) % 4; cb[1] = (lo + 1) % 3; cb[2] = hi;
                            cb[3] = (m + 1) % 3; cb[4] = (hi == lo) ? 1 - sel : sel;
                            cb[5] = (m != 1) ? 1 : 0; cb[6] = 1 - ca[6];
                            run_pair(logic'((hi + m) % 2));
                        end

        // R7: disabling mid-run hands the pin to the software bits at once
        ca[0] = 1; ca[1] = 2; ca[2] = 1; ca[3] = 5; ca[4] = 0; ca[5] = 1; ca[6] = 0;
        @(negedge clk);
        apply(ca);
        en_i = 1'b1; tx_mode_i = 1'b1;
        for (int s = 0; s < 4; s++) begin
            repeat (7) @(negedge clk);
            en_i = 1'b0;
            sw_level_i = s[0];
            sw_oe_i = s[1];
            #1;
            chk("R7 tx disabled", tx_o, s[0]);
            chk("R7 oe disabled", tx_oe_o, s[1]);
            repeat (3) begin
                @(negedge clk);
                chk("R7 tx held", tx_o, s[0]);
                chk("R8 no done when disabled", done_o, 1'b0);
            end
            en_i = 1'b1;
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule